// File: doc/BRIEF.md
# Programmable Clock Output Channel

One channel of a programmable clock output. The channel picks one of four source clocks, divides it by a power of two from 1 to 64, and drives the result on an output signal while its enable input is high. A design instantiates it four times, once for each output. The shared system clock enable and disable logic supplies the `ch_en` input of each instance, and a status register can read `ch_en` as the active state of the channel.

The channel is modelled synchronously. Each source clock appears as a one-cycle enable pulse (`src_tick`) on a single fast clock `clk`. A write to the configuration updates a pending copy of the settings and clears `ready`. The channel then moves the pending settings into the active copy at the next divider wrap, and raises `ready` in the same cycle. A disabled channel wraps on every cycle, so the expected flow is: disable the channel, write the new settings, wait for `ready`, then enable it again. Switching between sources while enabled is not glitch-protected.

Top module: `pclk_channel`

## Requirements
- R1: `cfg_sel` is a 2-bit index into `src_tick`. Only pulses of the selected source (bit `cfg_sel` of `src_tick`) affect `clk_out`, and pulses on the other bits have no effect.
- R2: `cfg_exp` holds n, and the division ratio is 2^n. With n = 0, `clk_out` is high in the cycle after each selected pulse and low otherwise.
- R3: With n from 1 to 6, `clk_out` starts low when the channel is enabled and toggles on every 2^(n-1)-th selected pulse. The pulses are counted from the first cycle in which `ch_en` is high, so the output period is 2^n pulses.
- R4: The reserved code `cfg_exp` = 7 divides by 64, the same as code 6.
- R5: While `ch_en` is low, `clk_out` is low one cycle later, and the divider count restarts from zero at the next enable.
- R6: A write (`cfg_we` high) makes `ready` low in the next cycle.
- R7: Pending settings take effect at the next divider wrap, and `ready` goes high in that same cycle. While the channel is disabled, a wrap happens on every cycle. While it is enabled, a wrap happens on a selected pulse that ends a full output period (the pulse that drives `clk_out` from high to low), or on every selected pulse when n = 0.
- R8: After reset, `ready` is high, `clk_out` is low, and the active settings are source 0 with ratio 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock on which all logic runs |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One enable pulse per source clock edge |
| ch_en | input | 1 | Channel enable from the system clock enable logic |
| cfg_we | input | 1 | Write strobe for the configuration |
| cfg_sel | input | 2 | Source index written to the configuration |
| cfg_exp | input | 3 | Prescaler exponent written to the configuration |
| clk_out | output | 1 | Divided clock output |
| ready | output | 1 | High when the active settings match the last write |

## Verification
The main sweep covers every combination of source index and exponent code, including the reserved code 7. The four sources pulse at different rates (every 1, 2, 3 and 4 cycles), so a wrong source selection shows up as a wrong output period. Each combination starts from a freshly enabled channel, and the expected output after t counted pulses is floor(t / 2^(n-1)) mod 2. This tells apart errors in the toggle interval, the starting phase and the counter restart. A separate sequence reconfigures the channel while it is enabled and checks that the new ratio appears exactly at the end of the running period, two cycles after the write.

// File: rtl/pclk_channel.sv
module pclk_channel #(
  parameter int NSRC    = 4,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 3,
  parameter int MAX_EXP = 6,
  localparam int CNT_W  = (MAX_EXP > 1) ? MAX_EXP - 1 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             ch_en,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DIV_W-1:0] cfg_exp,
  output logic             clk_out,
  output logic             ready
);

  logic [SEL_W-1:0] pend_sel, act_sel;
  logic [DIV_W-1:0] pend_exp, act_exp;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half_m1;
  logic             out_q, rdy_q;
  logic             tick, last, wrap;
  logic [DIV_W-1:0] exp_clamped;

  assign tick        = src_tick[act_sel];
  assign half_m1     = (act_exp == '0) ? '0
                       : (((CNT_W+1)'(1)) << (act_exp - DIV_W'(1))) - (CNT_W+1)'(1);
  assign last        = (cnt == half_m1[CNT_W-1:0]);
  assign wrap        = !ch_en || (tick && ((act_exp == '0) || (last && out_q)));
  assign exp_clamped = (cfg_exp > DIV_W'(MAX_EXP)) ? DIV_W'(MAX_EXP) : cfg_exp;
  assign clk_out     = out_q;
  assign ready       = rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sel <= '0;
      pend_exp <= '0;
      act_sel  <= '0;
      act_exp  <= '0;
      cnt      <= '0;
      out_q    <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      if (!ch_en) begin
        cnt   <= '0;
        out_q <= 1'b0;
      end else if (act_exp == '0) begin
        out_q <= tick;
      end else if (tick) begin
        if (last) begin
          cnt   <= '0;
          out_q <= ~out_q;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end

      if (cfg_we) begin
        pend_sel <= cfg_sel;
        pend_exp <= exp_clamped;
        rdy_q    <= 1'b0;
      end else if (wrap && !rdy_q) begin
        act_sel <= pend_sel;
        act_exp <= pend_exp;
        rdy_q   <= 1'b1;
      end
    end
  end

  // R5: a disabled channel drives low on the following cycle
  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !clk_out);

  // R6: any write drops the ready flag
  assert_we_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !ready);

  // R7: while disabled, pending settings are applied on the next cycle
  assert_disabled_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !cfg_we && !ready) |=> ready);

  // R7: ready only rises after a wrap
  assert_rise_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(wrap));

  // R3: divided output only moves on a selected pulse
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !tick && act_exp != '0) |=> $stable(clk_out));

  // R3: the half-period counter never passes its terminal value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} <= half_m1));

endmodule

// File: tb/pclk_channel_tb.sv
module pclk_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic       ch_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_exp = '0;
  logic       clk_out, ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pclk_channel u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ch_en(ch_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_exp(cfg_exp),
    .clk_out(clk_out), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R8 ready after reset", ready, 1);
    chk(clk_out == 1'b0, "R8 out after reset", clk_out, 0);

    // R8/R2: default settings pass source 0 straight through
    ch_en = 1'b1;
    begin
      bit prev = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i > 0) chk(clk_out == prev, "R8 default pass-through", clk_out, prev);
        src_tick = {3'b111, i[0]};
        prev = i[0];
      end
    end
    ch_en = 1'b0;
    src_tick = '0;
    @(negedge clk);

    // R1..R5: sweep every source and exponent code
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 8; d++) begin
        int n, h, nt;
        bit prev;
        n = (d > 6) ? 6 : d;
        h = (n == 0) ? 1 : (1 << (n - 1));
        cfg_we = 1'b1; cfg_sel = s[1:0]; cfg_exp = d[2:0];
        @(negedge clk);
        cfg_we = 1'b0;
        chk(ready == 1'b0, "R6 write clears ready", ready, 0);
        @(negedge clk);
        chk(ready == 1'b1, "R7 disabled apply", ready, 1);
        chk(clk_out == 1'b0, "R5 disabled low", clk_out, 0);
        nt = 0; prev = 0; cyc = 0;
        ch_en = 1'b1;
        while (nt < 140) begin
          int e;
          bit t;
          if (n == 0) e = prev;
          else e = (nt / h) % 2;
          if (cyc > 0) begin
            if (d == 7) chk(clk_out == e[0], "R4 reserved code", clk_out, e);
            else if (n == 0) chk(clk_out == e[0], "R2 ratio one", clk_out, e);
            else chk(clk_out == e[0], "R3 R1 divided output", clk_out, e);
          end
          for (int k = 0; k < 4; k++) src_tick[k] = ((cyc % (k + 1)) == 0);
          t = src_tick[s];
          prev = t;
          nt += t;
          cyc++;
          @(negedge clk);
        end
        ch_en = 1'b0;
        src_tick = '0;
        @(negedge clk);
        chk(clk_out == 1'b0, "R5 low after disable", clk_out, 0);
      end
    end

    // R7: reconfigure while enabled, applied at end of running period
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_exp = 3'd2;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    ch_en = 1'b1;
    src_tick = 4'b1111;
    repeat (5) @(negedge clk);
    cfg_we = 1'b1; cfg_exp = 3'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    begin
      int low = 0;
      while (ready == 1'b0 && low < 10) begin
        low++;
        @(negedge clk);
      end
      chk(low == 2, "R7 ready low until wrap", low, 2);
      for (int i = 0; i < 6; i++) begin
        chk(clk_out == i[0], "R7 new ratio after wrap", clk_out, i[0]);
        @(negedge clk);
      end
    end
    ch_en = 1'b0;
    src_tick = '0;
    @(negedge clk);
    finish_run();
  end
endmodule